// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the counting core of a pulse-width timer. It divides a qualified system clock with a two-stage prescaler. On each prescaled tick it advances a 16-bit counter, which can count upward, downward, up and then down, or stay frozen. The counter's cycle length comes from an active period register. Software can load that register directly, or stage a new value in a shadow copy that takes effect only when the counter next reaches zero, so a running waveform never sees a torn cycle.

Software drives the block through a single-word write port that selects either the control word or the period. A run field in the control word halts counting at once, lets the current cycle finish and then halts, or lets the counter run freely. Downstream compare and output logic consumes the counter value, the direction flag, the prescaled tick and two single-cycle events that mark the counter arriving at zero and arriving at the period.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, both events and the direction flag are low, the counter is halted, the active and shadow periods are 0, and the control word is 0.
- R2: The prescaler advances only in cycles with clkEn high. `tick` is high in one of every D such cycles, where D = H * 2^C. H is 1 when control bits 9:7 are 0, and is otherwise twice their value. C is control bits 12:10. Any control write restarts the prescaler count.
- R3: With mode bits 1:0 = 00 the counter counts up by one on each counting tick. When it is at or above the active period, it returns to 0 instead.
- R4: With mode 01 the counter counts down by one on each counting tick. When it is at 0, it reloads the active period instead. `dirDown` is high in this mode.
- R5: With mode 10 the counter counts up until it reaches the active period, then counts down to 0, then counts up again. `dirDown` is high while it is descending, and a control write resets it to ascending.
- R6: With mode 11 the counter keeps its value on ticks and produces no events.
- R7: `zeroEvt` and `periodEvt` are high for one cycle, right after the counting tick that moved the count to 0 or to the active period, respectively.
- R8: Run bits 15:14 = 00 hold the counter with no events. When bit 15 is 1, the counter counts on every tick.
- R9: Run bits 15:14 = 01 keep the counter counting until a tick brings it to 0. It then holds at 0 until the next control write.
- R10: When control bit 3 is 1, a period write updates the active period at once. When bit 3 is 0, the write goes to the shadow only, and the shadow is copied into the active period on the counting tick that brings the count to 0.
- R11: When wrEn is high, wrAddr 0 writes the control word and wrAddr 1 writes the period. When wrEn is low, wrData and wrAddr have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | System clock qualifier that feeds the prescaler |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Register select: 0 control, 1 period |
| wrData | input | 16 | Write data |
| count | output | 16 | Current counter value |
| zeroEvt | output | 1 | One-cycle pulse: count arrived at 0 |
| periodEvt | output | 1 | One-cycle pulse: count arrived at the active period |
| dirDown | output | 1 | High while the counter is descending |
| tick | output | 1 | Prescaled tick strobe (combinational) |

## Verification
A register write takes effect at the clock edge that samples it. `tick` is combinational from the prescaler state and clkEn, so it is due in the same cycle. The count and both events move at the edge where a counting tick is seen, so they are due one cycle after that tick. `dirDown` follows the mode at once and follows a turning point at that same edge. The bench drives inputs at the falling edge and compares every output at the following falling edge against a cycle model updated at the rising edge. The directed cases wait for an event pulse and check the values due on that cycle or a known number of cycles after it.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
  // Control word field positions (software visible)
  localparam int RUN_HI  = 15;
  localparam int RUN_LO  = 14;
  localparam int CK_HI   = 12;
  localparam int CK_LO   = 10;
  localparam int HS_HI   = 9;
  localparam int HS_LO   = 7;
  localparam int IMM_BIT = 3;
  localparam int MODE_HI = 1;
  localparam int MODE_LO = 0;
  localparam int SEL_W   = CK_HI - CK_LO + 1;

  typedef enum logic [1:0] {
    MODE_UP     = 2'b00,
    MODE_DOWN   = 2'b01,
    MODE_UPDOWN = 2'b10,
    MODE_FREEZE = 2'b11
  } cntMode_e;

  typedef struct packed {
    logic [1:0]       run;
    logic [SEL_W-1:0] ckSel;
    logic [SEL_W-1:0] hsSel;
    logic             prdImm;
    cntMode_e         mode;
  } ctrlWord_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     step;
    logic     ctrlWr;
    logic     prdWr;
    logic     prdImm;
    cntMode_e mode;
  } tbStrobe_t;
endpackage

// File: rtl/pwm_tb_ctrl.sv
module pwm_tb_ctrl
  import pwm_tb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      clkEn,
  input  logic      wrEn,
  input  logic      wrAddr,
  input  ctrlWord_t ctrlIn,
  input  logic      nextZero,
  output tbStrobe_t stb,
  output logic      tick
);
  // widest divisor: 2*(2^SEL_W-1) << (2^SEL_W-1)
  localparam int HS_MUL_W = SEL_W + 1;
  localparam int PS_W     = HS_MUL_W + (1 << SEL_W) - 1;

  ctrlWord_t        ctrlQ;
  logic [PS_W-1:0]  psCnt;
  logic [PS_W-1:0]  psLast;
  logic [PS_W-1:0]  hsMul;
  logic             cycDone;
  logic             ctrlWr;
  logic             prdWr;
  logic             runCyc;
  logic             runOk;
  logic             step;

  assign ctrlWr = wrEn & ~wrAddr;
  assign prdWr  = wrEn & wrAddr;

  always_comb begin
    if (ctrlQ.hsSel == '0) hsMul = PS_W'(1);
    else                   hsMul = PS_W'({ctrlQ.hsSel, 1'b0});
    psLast = (hsMul << ctrlQ.ckSel) - PS_W'(1);
  end

  assign tick   = clkEn & (psCnt == psLast);
  assign runCyc = (ctrlQ.run == 2'b01);
  assign runOk  = ctrlQ.run[1] | (runCyc & ~cycDone);
  assign step   = tick & (ctrlQ.mode != MODE_FREEZE) & runOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ <= ctrlIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (ctrlWr) begin
      psCnt <= '0;
    end else if (clkEn) begin
      psCnt <= (psCnt == psLast) ? '0 : psCnt + PS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycDone <= 1'b0;
    end else if (ctrlWr) begin
      cycDone <= 1'b0;
    end else if (step & nextZero & runCyc) begin
      cycDone <= 1'b1;
    end
  end

  always_comb begin
    stb.step   = step;
    stb.ctrlWr = ctrlWr;
    stb.prdWr  = prdWr;
    stb.prdImm = ctrlQ.prdImm;
    stb.mode   = ctrlQ.mode;
  end
endmodule

// File: rtl/pwm_tb_datapath.sv
module pwm_tb_datapath
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tbStrobe_t        stb,
  input  logic [CNT_W-1:0] prdIn,
  output logic [CNT_W-1:0] count,
  output logic             zeroEvt,
  output logic             periodEvt,
  output logic             dirDown,
  output logic             nextZero
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] prdAct;
  logic [CNT_W-1:0] prdShd;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W:0]   incW;
  logic             udDown;
  logic             flip;

  assign incW = {1'b0, cnt} + (CNT_W+1)'(1);

  always_comb begin
    nextCnt = cnt;
    flip    = 1'b0;
    unique case (stb.mode)
      MODE_UP:   nextCnt = (cnt >= prdAct) ? '0 : incW[CNT_W-1:0];
      MODE_DOWN: nextCnt = (cnt == '0) ? prdAct : cnt - CNT_W'(1);
      MODE_UPDOWN: begin
        if (udDown) begin
          flip    = (cnt <= CNT_W'(1));
          nextCnt = flip ? '0 : cnt - CNT_W'(1);
        end else begin
          flip    = (incW >= {1'b0, prdAct});
          nextCnt = flip ? prdAct : incW[CNT_W-1:0];
        end
      end
      MODE_FREEZE: nextCnt = cnt;
    endcase
  end

  assign nextZero = (nextCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      zeroEvt   <= 1'b0;
      periodEvt <= 1'b0;
    end else begin
      if (stb.step) cnt <= nextCnt;
      zeroEvt   <= stb.step & nextZero;
      periodEvt <= stb.step & (nextCnt == prdAct);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prdShd <= '0;
      prdAct <= '0;
    end else begin
      if (stb.prdWr) prdShd <= prdIn;
      if (stb.prdWr & stb.prdImm) begin
        prdAct <= prdIn;
      end else if (stb.step & nextZero & ~stb.prdImm) begin
        prdAct <= prdShd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      udDown <= 1'b0;
    end else if (stb.ctrlWr) begin
      udDown <= 1'b0;
    end else if (stb.step & flip) begin
      udDown <= ~udDown;
    end
  end

  assign count   = cnt;
  assign dirDown = (stb.mode == MODE_DOWN) | ((stb.mode == MODE_UPDOWN) & udDown);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             wrEn,
  input  logic             wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic             zeroEvt,
  output logic             periodEvt,
  output logic             dirDown,
  output logic             tick
);
  ctrlWord_t ctrlIn;
  tbStrobe_t stb;
  logic      nextZero;

  always_comb begin
    ctrlIn.run    = wrData[RUN_HI:RUN_LO];
    ctrlIn.ckSel  = wrData[CK_HI:CK_LO];
    ctrlIn.hsSel  = wrData[HS_HI:HS_LO];
    ctrlIn.prdImm = wrData[IMM_BIT];
    ctrlIn.mode   = cntMode_e'(wrData[MODE_HI:MODE_LO]);
  end

  pwm_tb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .ctrlIn   (ctrlIn),
    .nextZero (nextZero),
    .stb      (stb),
    .tick     (tick)
  );

  pwm_tb_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .prdIn     (wrData),
    .count     (count),
    .zeroEvt   (zeroEvt),
    .periodEvt (periodEvt),
    .dirDown   (dirDown),
    .nextZero  (nextZero)
  );
endmodule

// File: rtl/pwm_tb_chk.sv
module pwm_tb_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkEn,
  input logic             tick,
  input logic             step,
  input logic [CNT_W-1:0] count,
  input logic             zeroEvt,
  input logic             periodEvt
);
  // R2
  tick_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> clkEn);

  // R8
  step_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    step |-> tick);

  // R7
  zero_evt_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroEvt |-> (count == '0));

  // R7
  evt_after_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (zeroEvt || periodEvt) |-> $past(step));

  // R6
  hold_without_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(step) |-> $stable(count));
endmodule

bind pwm_timebase pwm_tb_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clkEn     (clkEn),
  .tick      (tick),
  .step      (stb.step),
  .count     (count),
  .zeroEvt   (zeroEvt),
  .periodEvt (periodEvt)
);

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrAddr = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] count;
  logic        zeroEvt, periodEvt, dirDown, tick;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  pwm_timebase dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .count(count), .zeroEvt(zeroEvt), .periodEvt(periodEvt),
    .dirDown(dirDown), .tick(tick)
  );

  always #4 clk = ~clk;

  // ---------------- reference model, updated at the rising edge ----------
  logic [15:0] mCtrl, mCnt, mPrdA, mPrdS;
  int          mPs;
  logic        mUd, mDone, mZ, mP;

  function automatic int divOf(logic [15:0] c);
    int hs = int'(c[9:7]);
    int ck = int'(c[12:10]);
    return ((hs == 0) ? 1 : 2 * hs) << ck;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = '0; mCnt = '0; mPrdA = '0; mPrdS = '0;
      mPs = 0; mUd = 0; mDone = 0; mZ = 0; mP = 0;
    end else begin
      int          last;
      logic        tk, runCyc, stp, flp, cw, pw;
      logic [15:0] nx;
      logic [1:0]  md;
      last   = divOf(mCtrl) - 1;
      tk     = clkEn && (mPs == last);
      md     = mCtrl[1:0];
      runCyc = (mCtrl[15:14] == 2'b01);
      stp    = tk && (md != 2'b11) && (mCtrl[15] || (runCyc && !mDone));
      cw     = wrEn && !wrAddr;
      pw     = wrEn && wrAddr;
      flp    = 0;
      nx     = mCnt;
      case (md)
        2'b00: nx = (mCnt >= mPrdA) ? 16'd0 : mCnt + 16'd1;
        2'b01: nx = (mCnt == 0) ? mPrdA : mCnt - 16'd1;
        2'b10: begin
          if (mUd) begin flp = (mCnt <= 1); nx = flp ? 16'd0 : mCnt - 16'd1; end
          else begin
            flp = ({1'b0, mCnt} + 17'd1 >= {1'b0, mPrdA});
            nx = flp ? mPrdA : mCnt + 16'd1;
          end
        end
        default: nx = mCnt;
      endcase
      mZ = stp && (nx == 0);
      mP = stp && (nx == mPrdA);
      if (cw) mDone = 0; else if (stp && nx == 0 && runCyc) mDone = 1;
      if (cw) mUd = 0; else if (stp && flp) mUd = ~mUd;
      if (pw && mCtrl[3]) mPrdA = wrData;
      else if (stp && nx == 0 && !mCtrl[3]) mPrdA = mPrdS;
      if (pw) mPrdS = wrData;
      if (cw) mPs = 0; else if (clkEn) mPs = (mPs == last) ? 0 : mPs + 1;
      if (stp) mCnt = nx;
      if (cw) mCtrl = wrData;
    end
  end

  // ---------------- checking ------------------------------------------------
  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic string modeReq(logic [1:0] md);
    case (md)
      2'b00: return "R3 up count";
      2'b01: return "R4 down count";
      2'b10: return "R5 up-down count";
      default: return "R6 freeze count";
    endcase
  endfunction

  task automatic compareAll();
    logic expDir, expTick;
    expDir  = (mCtrl[1:0] == 2'b01) || (mCtrl[1:0] == 2'b10 && mUd);
    expTick = clkEn && (mPs == divOf(mCtrl) - 1);
    chk(modeReq(mCtrl[1:0]), 32'(count), 32'(mCnt));
    chk("R7 zero event", 32'(zeroEvt), 32'(mZ));
    chk("R7 period event", 32'(periodEvt), 32'(mP));
    chk("R5 direction", 32'(dirDown), 32'(expDir));
    chk("R2 tick", 32'(tick), 32'(expTick));
  endtask

  task automatic drive(logic en, logic we, logic wa, logic [15:0] wd);
    clkEn = en; wrEn = we; wrAddr = wa; wrData = wd;
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle();
    drive(1'b1, 1'b0, 1'b0, 16'h0000);
  endtask

  task automatic wr(logic wa, logic [15:0] wd);
    drive(1'b1, 1'b1, wa, wd);
  endtask

  task automatic waitPeriodEvt(int limit, output bit seen);
    seen = 0;
    for (int i = 0; i < limit && !seen; i++) begin
      idle();
      if (periodEvt) seen = 1;
    end
  endtask

  // ---------------- watchdog ----------------------------------------------
  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  // ---------------- stimulus -----------------------------------------------
  initial begin
    logic [15:0] held;
    int ticks;
    bit seen;
    bit evtSeen;
    void'($urandom(32'h5eed_1234));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", 32'(count), 0);
    chk("R1 zeroEvt", 32'(zeroEvt), 0);
    chk("R1 periodEvt", 32'(periodEvt), 0);
    chk("R1 dirDown", 32'(dirDown), 0);

    // R3 / R10 immediate / R11: up mode, period 3, divide by 1
    wr(1'b0, 16'h0008);
    wr(1'b1, 16'd3);
    wr(1'b0, 16'hC008);
    idle(); idle(); idle();
    chk("R3 up reaches period", 32'(count), 3);
    chk("R7 period event at top", 32'(periodEvt), 1);
    idle();
    chk("R3 up wraps to zero", 32'(count), 0);
    chk("R7 zero event at wrap", 32'(zeroEvt), 1);

    // R6 freeze
    wr(1'b0, 16'hC00B);
    held = count;
    evtSeen = 0;
    repeat (10) begin idle(); evtSeen |= zeroEvt | periodEvt; end
    chk("R6 freeze holds count", 32'(count), 32'(held));
    chk("R6 freeze no events", 32'(evtSeen), 0);

    // R8 run field 00 stops
    wr(1'b0, 16'h0008);
    held = count;
    repeat (10) idle();
    chk("R8 stopped holds count", 32'(count), 32'(held));

    // R2 prescaler: H=6 (field 3), 2^2 -> 24
    wr(1'b0, 16'h0988);
    ticks = int'(tick);
    repeat (119) begin idle(); ticks += int'(tick); end
    chk("R2 ticks in 120 cycles at divide 24", 32'(ticks), 5);

    // R4 down mode
    wr(1'b0, 16'hC009);
    seen = 0;
    for (int i = 0; i < 10 && !seen; i++) begin idle(); if (zeroEvt) seen = 1; end
    chk("R4 down reaches zero", 32'(seen), 1);
    idle();
    chk("R4 down reloads period", 32'(count), 3);
    chk("R4 reload period event", 32'(periodEvt), 1);
    chk("R4 direction down", 32'(dirDown), 1);

    // R5 up-down
    wr(1'b0, 16'hC00A);
    waitPeriodEvt(10, seen);
    chk("R5 turns at period", 32'(count), 3);
    chk("R5 descending after top", 32'(dirDown), 1);
    idle(); idle(); idle();
    chk("R5 reaches zero", 32'(count), 0);
    chk("R5 zero event", 32'(zeroEvt), 1);
    chk("R5 ascending after bottom", 32'(dirDown), 0);

    // R9 stop at end of cycle
    wr(1'b0, 16'hC008);
    idle(); idle();
    wr(1'b0, 16'h4008);
    repeat (20) idle();
    chk("R9 halted at zero", 32'(count), 0);
    evtSeen = 0;
    repeat (10) begin idle(); evtSeen |= zeroEvt | periodEvt; end
    chk("R9 stays at zero", 32'(count), 0);
    chk("R9 no events while halted", 32'(evtSeen), 0);

    // R10 shadow load
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'd7);
    wr(1'b0, 16'hC000);
    waitPeriodEvt(10, seen);
    chk("R10 old period kept until zero", 32'(count), 3);
    waitPeriodEvt(12, seen);
    chk("R10 shadow applied after zero", 32'(count), 7);

    // R10 immediate load
    wr(1'b0, 16'hC008);
    wr(1'b1, 16'd5);
    waitPeriodEvt(12, seen);
    chk("R10 immediate period", 32'(count), 5);

    // R11 writes ignored without wrEn
    held = count;
    repeat (3) drive(1'b1, 1'b0, 1'b0, 16'hC00B);
    chk("R11 control not written", 32'(count != held), 1);
    repeat (2) drive(1'b1, 1'b0, 1'b1, 16'd1);
    waitPeriodEvt(12, seen);
    chk("R11 period not written", 32'(count), 5);

    // constrained random phase, checked every cycle against the model
    for (int n = 0; n < 6000; n++) begin
      int r = int'($urandom_range(0, 99));
      logic en = ($urandom_range(0, 3) != 0);
      if (r < 3) begin
        logic [1:0] run = 2'($urandom_range(0, 3));
        logic [2:0] ck  = 3'($urandom_range(0, 2));
        logic [2:0] hs  = 3'($urandom_range(0, 2));
        logic       imm = 1'($urandom_range(0, 1));
        logic [1:0] md  = 2'($urandom_range(0, 3));
        if (run == 2'b00 && $urandom_range(0, 1) == 1) run = 2'b11;
        drive(en, 1'b1, 1'b0, {run, 1'b0, ck, hs, 3'b000, imm, 1'b0, md});
      end else if (r < 6) begin
        drive(en, 1'b1, 1'b1, 16'($urandom_range(0, 20)));
      end else begin
        drive(en, 1'b0, 1'($urandom_range(0, 1)), 16'($urandom));
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule